// File: doc/BRIEF.md
# Streaming Tilt Coefficient Correlator

This block takes one frame of signed impulse-response samples over a valid/ready handshake and reduces it to a single tilt-compensation coefficient for a speech postfilter. It reads each sample only once. As the sample streams in, two sums are updated at the same time. The first is the energy sum, the sum of the squares of all samples. The second is the lag-one correlation, the sum of the products of each pair of adjacent samples. A one-sample delay register supplies the earlier sample of each pair.

After the last sample of a frame, both sums are arithmetically shifted right. A correlation that is zero or negative makes the result zero. A positive correlation is multiplied by a fixed gain in Q15 format and divided by the shifted energy. The divider is sequential and produces one quotient bit per cycle. The integer quotient is presented together with a one-cycle done pulse, and the block then accepts the next frame.

Top module: `tilt_corr`

## Requirements
- R1: A frame is exactly N_SAMP (22) samples. A sample is taken on a clock edge where in_valid_i and in_ready_o are both high. in_ready_o is high after reset and whenever no frame result is being computed.
- R2: The energy sum is the sum of the squares of all 22 samples in the frame.
- R3: The correlation sum is the sum of x[k]*x[k+1] for k = 0..20, which is 21 terms. The delay register is cleared at every frame start, so a sample from the previous frame never forms a term.
- R4: Both sums are arithmetically shifted right by SHIFT (8) bits, which rounds toward minus infinity, before the clamp and the division.
- R5: If the shifted correlation is zero or negative, coef_o is 0.
- R6: If the shifted energy is zero, no division is started and coef_o is 0.
- R7: Otherwise coef_o = floor((corr_sh * MU) / eng_sh), taken as an unsigned integer with MU = 26214. The result never exceeds MU.
- R8: done_o is high for exactly one cycle for each frame. coef_o holds its value until the next done pulse.
- R9: in_ready_o stays low from the edge that takes the 22nd sample until done_o rises. in_valid_i and in_data_i have no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Sample valid |
| in_data_i | input | 16 | Signed sample |
| in_ready_o | output | 1 | Block can accept a sample |
| done_o | output | 1 | One-cycle pulse, coef_o updated |
| coef_o | output | 16 | Tilt coefficient, unsigned integer quotient |

## Verification
A lag register that is not cleared at a frame boundary lets the last sample of one frame form an extra term with the first sample of the next frame. Two back-to-back frames of the same sign therefore return a wrong coefficient on the second done pulse. A sample counter that is off by one makes the frame the wrong length, so done_o comes early, or never comes until the bench sends extra samples. A divider or clamp fault shows up as a wrong value on coef_o at the first done pulse after the frame. A handshake fault shows up as in_ready_o going high during the 48-cycle division window, before the next frame has started.

// File: rtl/tilt_pkg.sv
package tilt_pkg;
  typedef enum logic [1:0] {
    ST_ACC  = 2'd0,
    ST_PREP = 2'd1,
    ST_DIV  = 2'd2
  } tilt_state_e;
endpackage

// File: rtl/tilt_mac.sv
module tilt_mac #(
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     take_i,
  input  logic                     first_i,
  input  logic signed [SAMP_W-1:0] x_i,
  output logic signed [ACC_W-1:0]  eng_o,
  output logic signed [ACC_W-1:0]  corr_o
);
  localparam int PW = 2 * SAMP_W;

  logic signed [SAMP_W-1:0] prev_q;
  logic signed [PW-1:0]     x_ext, p_ext, sq, lag;
  logic signed [ACC_W-1:0]  sq_acc, lag_acc;

  assign x_ext   = {{SAMP_W{x_i[SAMP_W-1]}}, x_i};
  assign p_ext   = {{SAMP_W{prev_q[SAMP_W-1]}}, prev_q};
  assign sq      = x_ext * x_ext;
  assign lag     = x_ext * p_ext;
  assign sq_acc  = {{(ACC_W-PW){sq[PW-1]}}, sq};
  assign lag_acc = {{(ACC_W-PW){lag[PW-1]}}, lag};

  // first sample restarts both sums and ignores the stale lag register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      eng_o  <= '0;
      corr_o <= '0;
    end else if (take_i) begin
      prev_q <= x_i;
      eng_o  <= first_i ? sq_acc : eng_o + sq_acc;
      corr_o <= first_i ? '0 : corr_o + lag_acc;
    end
  end

  AST_ENG_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_o[ACC_W-1]); // R2
  AST_FIRST_NO_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && first_i |=> corr_o == '0); // R3
endmodule

// File: rtl/tilt_div.sv
module tilt_div #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   shl, diff;

  assign shl  = {rem_q, quo_o[NUM_W-1]};
  assign diff = shl - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_o  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        den_q  <= den_i;
        quo_o  <= num_i;
        cnt_q  <= CNT_W'(NUM_W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (!diff[DEN_W]) begin
          rem_q <= diff[DEN_W-1:0];
          quo_o <= {quo_o[NUM_W-2:0], 1'b1};
        end else begin
          rem_q <= shl[DEN_W-1:0];
          quo_o <= {quo_o[NUM_W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  AST_NO_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> den_i != '0); // R6
  AST_REM_BELOW_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rem_q < den_q); // R7
endmodule

// File: rtl/tilt_corr.sv
module tilt_corr
  import tilt_pkg::*;
#(
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 40,
  parameter int N_SAMP = 22,
  parameter int SHIFT  = 8,
  parameter int MU_W   = 16,
  parameter int MU     = 26214,
  parameter int COEF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [SAMP_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              done_o,
  output logic [COEF_W-1:0] coef_o
);
  localparam int CNT_W = $clog2(N_SAMP);
  localparam int SH_W  = ACC_W - SHIFT;
  localparam int NUM_W = SH_W + MU_W;
  localparam logic [MU_W-1:0] MU_C = MU_W'(MU);

  tilt_state_e              st_q;
  logic [CNT_W-1:0]         cnt_q;
  logic                     take, last;
  logic signed [ACC_W-1:0]  eng, corr, eng_sh, corr_sh;
  logic                     corr_pos, eng_nz, div_go;
  logic [NUM_W-1:0]         num, quo;
  logic                     div_busy, div_done;

  assign in_ready_o = (st_q == ST_ACC);
  assign take       = in_valid_i && in_ready_o;
  assign last       = (cnt_q == CNT_W'(N_SAMP - 1));

  tilt_mac #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_mac (
    .clk_i, .rst_ni,
    .take_i (take),
    .first_i(cnt_q == '0),
    .x_i    (in_data_i),
    .eng_o  (eng),
    .corr_o (corr)
  );

  assign eng_sh   = eng >>> SHIFT;
  assign corr_sh  = corr >>> SHIFT;
  assign corr_pos = !corr_sh[ACC_W-1] && (corr_sh != '0);
  assign eng_nz   = (eng_sh != '0);
  assign div_go   = (st_q == ST_PREP) && corr_pos && eng_nz;
  assign num      = {{MU_W{1'b0}}, corr_sh[SH_W-1:0]} * {{SH_W{1'b0}}, MU_C};

  tilt_div #(.NUM_W(NUM_W), .DEN_W(SH_W)) u_div (
    .clk_i, .rst_ni,
    .start_i(div_go),
    .num_i  (num),
    .den_i  (eng_sh[SH_W-1:0]),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ACC;
      cnt_q  <= '0;
      done_o <= 1'b0;
      coef_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_ACC: if (take) begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) st_q <= ST_PREP;
        end
        ST_PREP: begin
          if (div_go) st_q <= ST_DIV;
          else begin
            coef_o <= '0;
            done_o <= 1'b1;
            st_q   <= ST_ACC;
          end
        end
        ST_DIV: if (div_done) begin
          coef_o <= quo[COEF_W-1:0];
          done_o <= 1'b1;
          st_q   <= ST_ACC;
        end
        default: st_q <= ST_ACC;
      endcase
    end
  end

  AST_READY_LOW_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_busy |-> !in_ready_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_COEF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(coef_o)); // R8
  AST_CORR_LE_ENG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PREP |-> corr_sh <= eng_sh); // R4
  AST_QUO_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done |-> quo <= NUM_W'(MU)); // R7
  AST_CLAMP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_PREP && !corr_pos |=> done_o && coef_o == '0); // R5
endmodule

// File: tb/tilt_corr_test.sv
module tilt_corr_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 22;
  localparam int MU = 26214;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, done;
  logic [15:0] coef;
  int errors = 0;
  int checks = 0;
  int s[N];

  always #(CLK_PERIOD/2) clk = ~clk;

  tilt_corr uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .done_o(done), .coef_o(coef)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model();
    longint e = 0, c = 0, es, cs;
    for (int k = 0; k < N; k++) e += longint'(s[k]) * s[k];
    for (int k = 0; k < N - 1; k++) c += longint'(s[k]) * s[k+1];
    es = e >>> 8;
    cs = c >>> 8;
    if (cs <= 0 || es == 0) return 0;
    return (cs * MU) / es;
  endfunction

  // junk: keep valid high with a large value while the result is computed
  task automatic run_frame(input string req, input bit junk);
    int ready_seen = 0;
    int wait_cyc = 0;
    longint exp = model();
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'(s[k]);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = junk;
    in_data  = 16'h7fff;
    while (!done && wait_cyc < 200) begin
      if (in_ready) ready_seen++;
      wait_cyc++;
      @(negedge clk);
    end
    check({req, " done seen"}, done, 1);
    check({"R9 ready low while computing (", req, ")"}, ready_seen, 0);
    check({req, " coef"}, coef, exp);
    in_valid = 1'b0;
    @(negedge clk);
    check({"R8 done one cycle (", req, ")"}, done, 0);
    check({"R8 coef held (", req, ")"}, coef, exp);
  endtask

  task automatic t_reset();
    check("R1 ready after reset", in_ready, 1);
    check("R8 done low after reset", done, 0);
    check("R8 coef zero after reset", coef, 0);
  endtask

  task automatic t_const();
    for (int k = 0; k < N; k++) s[k] = 1000;
    run_frame("R2 R3 R7 constant", 0);
  endtask

  task automatic t_alt();
    for (int k = 0; k < N; k++) s[k] = (k % 2) ? -2000 : 2000;
    run_frame("R5 negative corr", 0);
  endtask

  task automatic t_tiny();
    for (int k = 0; k < N; k++) s[k] = 3;
    run_frame("R6 energy shifts to zero", 0);
    for (int k = 0; k < N; k++) s[k] = 0;
    run_frame("R6 all zero", 0);
  endtask

  task automatic t_extreme();
    for (int k = 0; k < N; k++) s[k] = 32767;
    run_frame("R7 max positive", 0);
    for (int k = 0; k < N; k++) s[k] = -32768;
    run_frame("R4 R7 max negative", 0);
  endtask

  task automatic t_ramp();
    for (int k = 0; k < N; k++) s[k] = 1500 * k - 9000;
    run_frame("R4 R7 ramp", 0);
    for (int k = 0; k < N; k++) s[k] = (k == 0) ? 30000 : ((k == 1) ? 100 : 0);
    run_frame("R3 impulse pair", 0);
  endtask

  task automatic t_boundary();
    // first frame ends large, next starts large: a stale lag term would show
    for (int k = 0; k < N; k++) s[k] = (k == N - 1) ? 30000 : ((k % 2) ? 50 : -50);
    run_frame("R3 frame A", 1);
    for (int k = 0; k < N; k++) s[k] = (k == 0) ? 30000 : ((k % 3 == 0) ? 400 : 300);
    run_frame("R3 R9 frame B after junk", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_const();
    t_alt();
    t_tiny();
    t_extreme();
    t_ramp();
    t_boundary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule